// File: doc/BRIEF.md
# Opcode-Driven 64-bit ALU

The block is a 64-bit arithmetic and logic unit whose operation is chosen by a 4-bit code. It takes two operands, a 4-bit operation code and a 6-bit shift amount. It produces one 64-bit result from one of five functions:
- wrapping add
- wrapping subtract
- set-if-less
- logical left shift
- logical right shift

A separate flag marks any code that names no operation. One such code is reserved and must never be issued. For that code, and for every unassigned code, the flag rises and the result is forced to zero.

The datapath is combinational. A parameter adds an output register, which is on by default, so the result and flag appear one clock after the inputs. A second parameter switches the less-than comparison from unsigned to two's-complement signed. No carry or overflow indication is produced.

Top module: `alu64_core`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `illegal` are cleared to zero after that edge, whatever the other inputs are.
- R2: Code 4'b0001 gives `result` = `op_a` + `op_b` modulo 2^64.
- R3: Code 4'b0010 gives `result` = `op_a` - `op_b` modulo 2^64.
- R4: Code 4'b1011 with `SIGNED_SLT`=0 gives `result` = 64'h1 when `op_a` < `op_b` as unsigned numbers, and all zeros otherwise, including when they are equal.
- R5: With `SIGNED_SLT`=1, code 4'b1011 compares the operands as two's-complement signed numbers.
- R6: Code 4'b1100 shifts `op_a` left by `shamt` (0 to 63) and fills with zeros. A shift of 0 returns `op_a`.
- R7: Code 4'b1110 shifts `op_a` right by `shamt` (0 to 63) and fills with zeros. A shift of 0 returns `op_a`.
- R8: Code 4'b1000 (reserved) sets `illegal` to 1 and `result` to zero.
- R9: Every code other than 0001, 0010, 1011, 1100, 1110 and 1000 also sets `illegal` to 1 and `result` to zero.
- R10: The five assigned codes give `illegal` = 0.
- R11: With `REG_OUT`=1, the outputs keep their previous values until the next rising clock edge after the inputs change, and show the new values after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand; the shifted value |
| op_b | input | 64 | Second operand |
| opcode | input | 4 | Operation select code |
| shamt | input | 6 | Shift distance, 0 to 63 |
| result | output | 64 | Operation result |
| illegal | output | 1 | High for the reserved code or any unassigned code |

## Verification
The adder and subtractor are driven at the wrap points (all ones plus one, zero minus one) and with ordinary values, which shows that the carry chain and the operand inversion behave as modulo arithmetic. The comparison is tried with equal operands and with operand pairs whose sign bits differ. An unsigned and a signed instance are given the same inputs, so the test shows which comparison each one uses. The shifts use distances 0, 1, 63 and a sweep over all distances, with patterns whose ones sit at both ends of the word; this catches wrong fill bits and wrong stage weights. All sixteen codes are walked through, which separates the assigned codes from the reserved code and the unassigned ones, and checks that each illegal code gives a zero result.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_TRAP = 4'b1000,
    OP_SLT  = 4'b1011,
    OP_SHL  = 4'b1100,
    OP_SHR  = 4'b1110
  } alu_op_e;

  typedef struct packed {
    logic add;
    logic sub;
    logic slt;
    logic shl;
    logic shr;
  } alu_sel_t;

endpackage

// File: rtl/alu64_decode.sv
module alu64_decode
  import alu64_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_sel_t   sel_o,
  output logic       illegal_o
);

  always_comb begin
    sel_o     = '0;
    illegal_o = 1'b0;
    case (op_i)
      OP_ADD:  sel_o.add = 1'b1;
      OP_SUB:  sel_o.sub = 1'b1;
      OP_SLT:  sel_o.slt = 1'b1;
      OP_SHL:  sel_o.shl = 1'b1;
      OP_SHR:  sel_o.shr = 1'b1;
      default: illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu64_arith.sv
module alu64_arith #(
  parameter int DATA_W     = 64,
  parameter bit SIGNED_SLT = 1'b0
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   ext;
  logic              carry;

  // One adder serves both add and subtract: a + ~b + 1 for subtract.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign ext   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = ext[MSB:0];
  assign carry = ext[DATA_W];

  generate
    if (SIGNED_SLT) begin : g_signed
      // Different signs: a is smaller when it is negative.
      // Same signs: the difference cannot overflow, so its sign bit decides.
      assign lt_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    end else begin : g_unsigned
      // A borrow (no carry out of a - b) means a < b.
      assign lt_o = ~carry;
    end
  endgenerate

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 6
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               left_i,
  output logic [DATA_W-1:0]  out_o
);

  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] res_rev;
  logic [DATA_W-1:0] stage [0:SHAMT_W];

  // A left shift is done as a right shift of the bit-reversed word.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign a_rev[i]   = a_i[DATA_W-1-i];
      assign res_rev[i] = stage[SHAMT_W][DATA_W-1-i];
    end
  endgenerate

  assign src      = left_i ? a_rev : a_i;
  assign stage[0] = src;

  // Logarithmic barrel: stage k moves the word by 2**k when shamt bit k is set.
  generate
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      assign stage[k+1] = shamt_i[k] ? (stage[k] >> (1 << k)) : stage[k];
    end
  endgenerate

  assign out_o = left_i ? res_rev : stage[SHAMT_W];

endmodule

// File: rtl/alu64_core.sv
module alu64_core
  import alu64_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit SIGNED_SLT = 1'b0,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          op_a,
  input  logic [DATA_W-1:0]          op_b,
  input  logic [3:0]                 opcode,
  input  logic [$clog2(DATA_W)-1:0]  shamt,
  output logic [DATA_W-1:0]          result,
  output logic                       illegal
);

  localparam int SHAMT_W = $clog2(DATA_W);

  alu_sel_t          sel;
  logic              bad_op;
  logic [DATA_W-1:0] sum;
  logic              lt;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] res_nxt;

  alu64_decode u_decode (
    .op_i      (opcode),
    .sel_o     (sel),
    .illegal_o (bad_op)
  );

  alu64_arith #(
    .DATA_W     (DATA_W),
    .SIGNED_SLT (SIGNED_SLT)
  ) u_arith (
    .a_i   (op_a),
    .b_i   (op_b),
    .sub_i (sel.sub | sel.slt),
    .sum_o (sum),
    .lt_o  (lt)
  );

  alu64_shift #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W)
  ) u_shift (
    .a_i     (op_a),
    .shamt_i (shamt),
    .left_i  (sel.shl),
    .out_o   (sh_out)
  );

  // The select lines are one-hot; an illegal code leaves all of them low,
  // so the AND-OR mux yields zero without a separate clear.
  always_comb begin
    res_nxt = ({DATA_W{sel.add | sel.sub}} & sum)
            | ({DATA_W{sel.slt}}           & {{(DATA_W-1){1'b0}}, lt})
            | ({DATA_W{sel.shl | sel.shr}} & sh_out);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result  <= '0;
          illegal <= 1'b0;
        end else begin
          result  <= res_nxt;
          illegal <= bad_op;
        end
      end

      AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_ADD) |=> (result == $past(op_a + op_b))); // R2
      AST_SUB_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SUB) |=> (result == $past(op_a - op_b))); // R3
      AST_SLT_IS_BOOL: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SLT) |=> (result[DATA_W-1:1] == '0)); // R4
      AST_SHL_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SHL && shamt == '0) |=> (result == $past(op_a))); // R6
      AST_SHR_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SHR && shamt == '0) |=> (result == $past(op_a))); // R7
      AST_TRAP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_TRAP) |=> (illegal && result == '0)); // R8
      AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0)); // R9
      AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_ADD || opcode == OP_SUB || opcode == OP_SLT ||
         opcode == OP_SHL || opcode == OP_SHR) |=> !illegal); // R10
    end else begin : g_comb
      assign result  = res_nxt;
      assign illegal = bad_op;

      AST_TRAP_FLAGGED_C: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_TRAP) |-> (illegal && result == '0)); // R8
      AST_ILLEGAL_ZERO_C: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0)); // R9
    end
  endgenerate

endmodule

// File: tb/alu64_core_bench.sv
module alu64_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [3:0]  op = 4'b0000;
  logic [5:0]  sh = '0;
  logic [63:0] res_u, res_s;
  logic        ill_u, ill_s;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu64_core u_alu64_core (
    .clk (clk), .rst (rst), .op_a (a), .op_b (b),
    .opcode (op), .shamt (sh), .result (res_u), .illegal (ill_u)
  );

  alu64_core #(.SIGNED_SLT(1'b1)) u_alu64_core_signed (
    .clk (clk), .rst (rst), .op_a (a), .op_b (b),
    .opcode (op), .shamt (sh), .result (res_s), .illegal (ill_s)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge; outputs register at the next rising edge
  // and are sampled at the falling edge after it.
  task automatic apply(input logic [3:0] o, input logic [63:0] x,
                       input logic [63:0] y, input logic [5:0] s);
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op = 4'b1000; a = '1; b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 result in reset", res_u, 64'h0);
    chk("R1 illegal in reset", {63'h0, ill_u}, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_add();
    apply(4'b0001, 64'd2, 64'd2, 6'd0);
    chk("R2 2+2", res_u, 64'd4);
    apply(4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    chk("R2 wrap", res_u, 64'h0);
    apply(4'b0001, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 6'd0);
    chk("R2 mixed", res_u, 64'h1234_5678_9ABC_DEF0 + 64'h0FED_CBA9_8765_4321);
    chk("R10 add legal", {63'h0, ill_u}, 64'h0);
  endtask

  task automatic t_sub();
    apply(4'b0010, 64'd0, 64'd1, 6'd0);
    chk("R3 wrap", res_u, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'b0010, 64'd100, 64'd58, 6'd0);
    chk("R3 plain", res_u, 64'd42);
    chk("R10 sub legal", {63'h0, ill_u}, 64'h0);
  endtask

  task automatic t_slt();
    apply(4'b1011, 64'd3, 64'd7, 6'd0);
    chk("R4 3<7", res_u, 64'h1);
    chk("R5 3<7 signed", res_s, 64'h1);
    apply(4'b1011, 64'd7, 64'd7, 6'd0);
    chk("R4 equal", res_u, 64'h0);
    chk("R5 equal", res_s, 64'h0);
    apply(4'b1011, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    chk("R4 big vs 1", res_u, 64'h0);
    chk("R5 -1<1", res_s, 64'h1);
    apply(4'b1011, 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 6'd0);
    chk("R4 5<big", res_u, 64'h1);
    chk("R5 5 vs -3", res_s, 64'h0);
    chk("R10 slt legal", {63'h0, ill_u}, 64'h0);
  endtask

  task automatic t_shifts();
    apply(4'b1100, 64'h8000_0000_0000_0001, 64'h0, 6'd1);
    chk("R6 shl 1", res_u, 64'h2);
    apply(4'b1100, 64'h1, 64'h0, 6'd63);
    chk("R6 shl 63", res_u, 64'h8000_0000_0000_0000);
    apply(4'b1100, 64'hDEAD_BEEF_0123_4567, 64'h0, 6'd0);
    chk("R6 shl 0", res_u, 64'hDEAD_BEEF_0123_4567);
    apply(4'b1110, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd63);
    chk("R7 shr 63", res_u, 64'h1);
    apply(4'b1110, 64'h8000_0000_0000_0001, 64'h0, 6'd1);
    chk("R7 shr 1", res_u, 64'h4000_0000_0000_0000);
    apply(4'b1110, 64'hDEAD_BEEF_0123_4567, 64'h0, 6'd0);
    chk("R7 shr 0", res_u, 64'hDEAD_BEEF_0123_4567);
    for (int s = 0; s < 64; s++) begin
      apply(4'b1100, 64'hC3A5_0F0F_96E1_7B2D, 64'h0, s[5:0]);
      chk("R6 sweep", res_u, 64'hC3A5_0F0F_96E1_7B2D << s);
      apply(4'b1110, 64'hC3A5_0F0F_96E1_7B2D, 64'h0, s[5:0]);
      chk("R7 sweep", res_u, 64'hC3A5_0F0F_96E1_7B2D >> s);
    end
    chk("R10 shift legal", {63'h0, ill_u}, 64'h0);
  endtask

  task automatic t_trap();
    apply(4'b1000, 64'd9, 64'd4, 6'd3);
    chk("R8 flag", {63'h0, ill_u}, 64'h1);
    chk("R8 zero result", res_u, 64'h0);
  endtask

  task automatic t_unassigned();
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc;
      cc = c[3:0];
      if (cc != 4'b0001 && cc != 4'b0010 && cc != 4'b1011 &&
          cc != 4'b1100 && cc != 4'b1110 && cc != 4'b1000) begin
        apply(cc, 64'hFFFF_0000_FFFF_0000, 64'h1, 6'd5);
        chk("R9 flag", {63'h0, ill_u}, 64'h1);
        chk("R9 zero result", res_u, 64'h0);
      end
    end
  endtask

  task automatic t_latency();
    apply(4'b0001, 64'd1, 64'd2, 6'd0);
    @(negedge clk);
    op = 4'b0001; a = 64'd10; b = 64'd20;
    #5;
    chk("R11 holds before edge", res_u, 64'd3);
    @(posedge clk);
    @(negedge clk);
    chk("R11 updates after edge", res_u, 64'd30);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_slt();
    t_shifts();
    t_trap();
    t_unassigned();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule